// File: doc/BRIEF.md
# MDIO Clause 22 Management Initiator

This block is a memory-mapped initiator for the two-wire management bus that connects a MAC-side controller to external Ethernet PHYs. Software first sets a clock divider and, for a write, the 16-bit payload. It then writes a frame-setup word that names the start pattern, the opcode, the PHY address and the register address. When the launch bit of that word is set, the block runs one complete Clause 22 frame. It produces the management clock and drives the data pad, or releases it, through preamble, start, opcode, both addresses, turnaround and data.

A read frame leaves two results in a status word: the 16 bits returned by the PHY, and a read-OK flag. A PHY can signal a failed read by driving the second turnaround bit high. Software can poll the launch bit, which reads back as a busy flag. It can also wait for the level interrupt, which is raised when the frame ends and is cleared when the status word is read.

Top module: `mdio_c22_initiator`

## Requirements
- R1: Four registers are decoded on the byte address. The divider is at 0x20 and is 8 bits wide, with a reset value of 39. The write payload is at 0x24, in bits 15:0. The frame setup is at 0x28: launch/busy in bit 31, register address in 20:16, PHY address in 8:4, opcode in 3:2, start pattern in 1:0. The status word is at 0x2C: read data in bits 15:0, read-OK in bit 24. Unlisted bits read as 0.
- R2: While a frame runs, one management clock period is 2 × (divider + 1) cycles of the input clock, with equal high and low halves.
- R3: A divider value of 0 is invalid and behaves as a value of 1, which gives a period of 4 input clocks.
- R4: Every frame is 64 bit times long. In order, it sends 32 ones, the 2-bit start field, the 2-bit opcode field, then the PHY address and the register address, each MSB first.
- R5: In any frame whose opcode is not 2, the pad stays driven for all 64 bits. The turnaround is sent as 1 then 0, and is followed by the 16-bit payload, MSB first.
- R6: In a frame with opcode 2 (read), the output enable is low from bit 46 (the first turnaround bit) through bit 63. The 16 bits sampled in bits 48 to 63 appear MSB first in status bits 15:0.
- R7: The read-OK flag is the inverse of the pad level sampled in bit 47 (the second turnaround bit) of a read frame.
- R8: Writing 0x28 with bit 31 set while idle starts a frame, and bit 31 then reads as 1 until the frame is complete. Writing 0x28 with bit 31 clear while idle stores the fields and starts nothing.
- R9: A write to 0x28 while a frame is busy has no effect, neither on the frame in progress nor on the stored fields.
- R10: The interrupt output goes high when a frame completes and stays high until the status word at 0x2C is read.
- R11: Between frames the management clock is low and the output enable is low.
- R12: The pad output changes only while the management clock is low. It is launched after the falling edge, and the input is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Frame-complete interrupt, level high |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pad output value |
| mdio_oe | output | 1 | Data pad output enable |
| mdio_i | input | 1 | Data pad input value |

## Verification
The bench sweeps divider values 0 to 3 and, for each one, runs alternating write and read frames with varied addresses and payloads. A responder answers read frames and drives either level in the second turnaround bit. Four corner cases get direct checks. A divider of 0 must give a 4-cycle period; an unguarded counter would stretch each half period to 256 cycles. Bit 47 is the boundary of read-OK capture, where an off-by-one would report the turnaround value of the wrong bit. The output enable must drop exactly at bit 46; releasing it late makes the initiator fight the PHY. A launch attempt in the middle of a frame must leave both the bit stream and the stored fields untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;

  localparam logic [7:0] OFS_DIV   = 8'h20;
  localparam logic [7:0] OFS_WDATA = 8'h24;
  localparam logic [7:0] OFS_SETUP = 8'h28;
  localparam logic [7:0] OFS_STAT  = 8'h2C;

  localparam logic [1:0] OPC_READ = 2'b10;

  typedef struct packed {
    logic [4:0] reg_a;
    logic [4:0] phy_a;
    logic [1:0] opc;
    logic [1:0] sof;
  } frame_setup_t;
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = (div == '0) ? DW'(1) : div;
    tick  = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  frame_setup_t  setup,
  input  logic [15:0]   wdata,
  input  logic [DW-1:0] div,
  input  logic          mdio_i,
  output logic          busy,
  output logic          done,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [15:0]   rd_data,
  output logic          rd_ok
);
  localparam int BW = $clog2(FRAME_BITS);

  logic                  tick, rise, fall, last;
  logic                  busy_q, busy_d, phase_q, phase_d, is_rd_q, is_rd_d;
  logic                  ok_q, ok_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [15:0]           rx_q, rx_d;

  mdio_tick_gen #(.DW(DW)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .div  (div),
    .tick (tick)
  );

  always_comb begin
    rise    = tick && !phase_q;
    fall    = tick && phase_q;
    last    = (bit_q == BW'(FRAME_BITS - 1));
    done    = fall && last;
    busy_d  = busy_q;
    phase_d = phase_q;
    is_rd_d = is_rd_q;
    ok_d    = ok_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    if (launch && !busy_q) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      bit_d   = '0;
      is_rd_d = (setup.opc == OPC_READ);
      tx_d    = {32'hFFFF_FFFF, setup.sof, setup.opc, setup.phy_a,
                 setup.reg_a, 2'b10, wdata};
    end else if (rise) begin
      phase_d = 1'b1;
      if (is_rd_q && bit_q == BW'(TA_SECOND)) ok_d = ~mdio_i;
      if (is_rd_q && bit_q >= BW'(DATA_FIRST)) rx_d = {rx_q[14:0], mdio_i};
    end else if (fall) begin
      phase_d = 1'b0;
      bit_d   = bit_q + BW'(1);
      tx_d    = {tx_q[FRAME_BITS-2:0], 1'b1};
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      is_rd_q <= 1'b0;
      ok_q    <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      is_rd_q <= is_rd_d;
      ok_q    <= ok_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign mdc     = phase_q;
  assign mdio_o  = tx_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(is_rd_q && bit_q >= BW'(TA_FIRST));
  assign rd_data = rx_q;
  assign rd_ok   = ok_q;

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe)); // R11
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mdc && $past(mdc)) |-> $stable(mdio_o)); // R12
  AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mdio_oe) |-> is_rd_q); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !mdc)); // R8
endmodule

// File: rtl/mdio_c22_initiator.sv
module mdio_c22_initiator
  import mdio_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [7:0]  DIV_RESET = 8'd39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  logic [DW-1:0] div_q, div_d;
  logic [15:0]   wdata_q, wdata_d;
  frame_setup_t  setup_q, setup_d;
  logic          irq_q, irq_d;
  logic          wr_div, wr_wdata, wr_setup, rd_stat, launch;
  logic          busy, done, rd_ok;
  logic [15:0]   rd_data;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[30:21], bus_wdata[15:9]};

  always_comb begin
    wr_div   = bus_sel && bus_wr && (bus_addr == AW'(OFS_DIV));
    wr_wdata = bus_sel && bus_wr && (bus_addr == AW'(OFS_WDATA));
    wr_setup = bus_sel && bus_wr && (bus_addr == AW'(OFS_SETUP));
    rd_stat  = bus_sel && !bus_wr && (bus_addr == AW'(OFS_STAT));
    launch   = wr_setup && !busy && bus_wdata[31];
    div_d    = wr_div   ? bus_wdata[DW-1:0] : div_q;
    wdata_d  = wr_wdata ? bus_wdata[15:0]   : wdata_q;
    setup_d  = setup_q;
    if (wr_setup && !busy) begin
      setup_d.reg_a = bus_wdata[20:16];
      setup_d.phy_a = bus_wdata[8:4];
      setup_d.opc   = bus_wdata[3:2];
      setup_d.sof   = bus_wdata[1:0];
    end
    if (done)         irq_d = 1'b1;
    else if (rd_stat) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DW'(DIV_RESET);
      wdata_q <= '0;
      setup_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      div_q   <= div_d;
      wdata_q <= wdata_d;
      setup_q <= setup_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFS_DIV):   bus_rdata = 32'(div_q);
        AW'(OFS_WDATA): bus_rdata = {16'h0, wdata_q};
        AW'(OFS_SETUP): bus_rdata = {busy, 10'h0, setup_q.reg_a, 7'h0,
                                     setup_q.phy_a, setup_q.opc, setup_q.sof};
        AW'(OFS_STAT):  bus_rdata = {7'h0, rd_ok, 8'h0, rd_data};
        default:        bus_rdata = '0;
      endcase
    end
  end

  mdio_frame_engine #(.DW(DW)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .setup  (setup_d),
    .wdata  (wdata_q),
    .div    (div_q),
    .mdio_i (mdio_i),
    .busy   (busy),
    .done   (done),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .rd_data(rd_data),
    .rd_ok  (rd_ok)
  );

  assign irq = irq_q;

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq); // R10
  AST_SETUP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_setup && busy) |=> $stable(setup_q)); // R9
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_stat) |=> irq); // R10
endmodule

// File: tb/mdio_c22_initiator_bench.sv
module mdio_c22_initiator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;

  int          n_chk = 0, n_fail = 0;
  longint      cyc = 0, t0 = 0, t1 = 0;
  int          rise_cnt = 0, glitch = 0;
  logic        mdc_q = 1'b0, mdo_q = 1'b1;
  logic        cap_o [64];
  logic        cap_oe[64];
  logic [15:0] resp_data = '0;
  logic        resp_ta2 = 1'b0;

  always #10 clk = ~clk;

  mdio_c22_initiator u_mdio_c22_initiator (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic resp_bit(int k);
    if (k == 47) return resp_ta2;
    if (k >= 48 && k < 64) return resp_data[63 - k];
    return 1'b1;
  endfunction

  assign mdio_i = resp_bit(rise_cnt);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mdc && !mdc_q) begin
      if (rise_cnt < 64) begin
        cap_o[rise_cnt]  = mdio_o;
        cap_oe[rise_cnt] = mdio_oe;
      end
      if (rise_cnt == 0) t0 = cyc;
      if (rise_cnt == 1) t1 = cyc;
      rise_cnt = rise_cnt + 1;
    end
    if (mdc && mdc_q && mdio_o !== mdo_q) glitch = glitch + 1;
    mdc_q = mdc;
    mdo_q = mdio_o;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic run_frame(input int p, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] data, input logic ta2);
    logic [31:0] v, word;
    logic [63:0] expv;
    int bit_err, oe_err, wait_n, eff;
    bit_err = 0; oe_err = 0; wait_n = 0;
    eff = (p == 0) ? 1 : p;
    wr(8'h20, 32'(p));
    wr(8'h24, {16'h0, data});
    resp_data = data; resp_ta2 = ta2;
    rise_cnt = 0;
    word = {1'b1, 10'h0, rg, 7'h0, phy, op, 2'b01};
    wr(8'h28, word);
    rd(8'h28, v);
    chk(v[31] == 1'b1, "R8", "busy during frame", v[31], 1);
    wr(8'h28, {1'b1, 10'h0, ~rg, 7'h0, ~phy, 2'b01, 2'b01}); // R9 ignored launch
    while (!irq && wait_n < 5000) begin @(negedge clk); wait_n++; end
    chk(irq == 1'b1, "R10", "irq after frame", irq, 1);
    expv = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, data};
    for (int k = 0; k < 64; k++) begin
      logic eoe;
      eoe = !(op == 2'b10 && k >= 46);
      if (cap_oe[k] !== eoe) oe_err++;
      if (eoe && cap_o[k] !== expv[63 - k]) bit_err++;
    end
    chk(rise_cnt == 64, "R4", "bit times per frame", rise_cnt, 64);
    chk(bit_err == 0, (op == 2'b10) ? "R4" : "R5", "frame bit errors", bit_err, 0);
    chk(oe_err == 0, (op == 2'b10) ? "R6" : "R5", "output-enable errors", oe_err, 0);
    chk(t1 - t0 == longint'(2 * (eff + 1)), (p == 0) ? "R3" : "R2", "mdc period",
        t1 - t0, 2 * (eff + 1));
    rd(8'h28, v);
    chk(v[31] == 1'b0, "R8", "busy cleared", v[31], 0);
    chk(v[30:0] == word[30:0], "R9", "setup unchanged by busy write", v[30:0], word[30:0]);
    chk(irq == 1'b1, "R10", "irq held until status read", irq, 1);
    rd(8'h2C, v);
    if (op == 2'b10) begin
      chk(v[15:0] == data, "R6", "read data", v[15:0], data);
      chk(v[24] == !ta2, "R7", "read-OK flag", v[24], !ta2);
    end
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq cleared by status read", irq, 0);
    chk(!mdc && !mdio_oe, "R11", "idle lines", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdc && !mdio_oe && !irq, "R11", "reset lines", {mdc, mdio_oe, irq}, 0);
    rd(8'h20, v);
    chk(v == 32'd39, "R1", "divider reset value", v, 39);
    rd(8'h28, v);
    chk(v == 32'h0, "R8", "setup reset value", v, 0);
    wr(8'h24, 32'hFFFF_BEEF);
    rd(8'h24, v);
    chk(v == 32'h0000_BEEF, "R1", "payload readback width", v, 32'hBEEF);
    wr(8'h28, 32'h0012_0345);
    rd(8'h28, v);
    chk(v == 32'h0012_0145, "R8", "stage without launch", v, 32'h0012_0145);
    repeat (50) @(negedge clk);
    chk(!irq && !mdc && rise_cnt == 0, "R8", "no frame without launch bit",
        {irq, mdc}, 0);
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j < 4; j++) begin
        logic [1:0] op;
        op = j[0] ? 2'b10 : 2'b01;
        run_frame(p, op, 5'((j * 7 + p * 3 + 1) % 32), 5'((j * 11 + p * 5 + 2) % 32),
                  16'hA5C3 ^ 16'(j * 16'h1111 + p), j[1]);
      end
    end
    chk(glitch == 0, "R12", "output changed while mdc high", glitch, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule